// File: doc/BRIEF.md
# Parallel Video Capture Front-End

This block sits at the pins of a parallel camera bus and turns the raw levels into a clean, single-clock-domain pixel stream. Every input can be set at run time: the active level of the line sync, the frame sync and the field line, whether the data bits arrive inverted, and which pixel-clock edge the bus is sampled on. A contiguous window of the 16-line physical data bus, given by a line count and a starting bit offset, is extracted as the pixel word and right-justified.

The outputs are always active-high. They are a pixel word qualified by a valid flag, a one-cycle line-start pulse, a one-cycle frame-start pulse and an even-field flag. A window that does not fit the physical bus is reported as a configuration error, and capture is held off while the error lasts. In slave mode the block makes the line and frame syncs itself from programmable active and total counts. It drives them out to the source with the configured polarities and uses them in place of the sync pins. In master mode the sync outputs rest at their inactive level.

Top module: `vid_cap_front`

## Requirements
- R1: The line sync pin is active when its level equals `cfg_hs_pol` (1 = active high, 0 = active low). `pix_valid` is high while the line sync is active and no configuration error is present. It responds two rising clock edges after the pins change.
- R2: The frame sync pin is active when its level equals `cfg_vs_pol`. `frame_start` is a one-cycle pulse on each inactive-to-active change of the frame sync. It has the same two-edge latency as R1.
- R3: `line_start` is a one-cycle pulse on each inactive-to-active change of the line sync. It coincides with the first valid pixel of the line.
- R4: When `cfg_data_pol` is 0, every data bit is inverted before the window is taken. When it is 1, the bits pass unchanged.
- R5: With `cfg_sample_rise` = 1 the bus is sampled on the rising clock edge. With 0 it is sampled on the falling edge and then retimed to the rising edge, so both modes have the same output latency.
- R6: `pix_data` holds the physical bits `[cfg_shift + cfg_width - 1 : cfg_shift]` in its low bits, with the upper bits zero.
- R7: `cfg_err` is 1 when `cfg_width` is 0 or `cfg_width + cfg_shift` exceeds 16. While the error is present, `pix_valid`, `line_start` and `frame_start` stay 0.
- R8: `field_even` is 1 when the field pin level equals `cfg_field_even_lvl`.
- R9: In slave mode (`cfg_slave` = 1) the generated line sync is active for `cfg_h_active` of every `cfg_h_total` cycles. The generated frame sync is active for `cfg_v_active` of every `cfg_v_total` lines. `gen_hs` and `gen_vs` present these syncs with the configured polarities. The sync pins are ignored.
- R10: In master mode `gen_hs` and `gen_vs` are held at their inactive level, which is the inverse of `cfg_hs_pol` and `cfg_vs_pol` respectively.
- R11: `pix_data` is zero whenever `pix_valid` is 0.
- R12: While `rst` is high, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hs_pol | input | 1 | Active level of the line sync |
| cfg_vs_pol | input | 1 | Active level of the frame sync |
| cfg_data_pol | input | 1 | 1 = data true, 0 = data inverted |
| cfg_field_even_lvl | input | 1 | Field pin level that marks the even field |
| cfg_sample_rise | input | 1 | 1 = rising-edge sampling, 0 = falling-edge sampling |
| cfg_width | input | 5 | Number of active data lines |
| cfg_shift | input | 4 | Lowest active physical data line |
| cfg_slave | input | 1 | 1 = block generates the syncs |
| cfg_h_active | input | 12 | Generated line sync active cycles |
| cfg_h_total | input | 12 | Generated line period in cycles |
| cfg_v_active | input | 12 | Generated frame sync active lines |
| cfg_v_total | input | 12 | Generated frame period in lines |
| pin_data | input | 16 | Physical data bus |
| pin_hs | input | 1 | Line sync from the source |
| pin_vs | input | 1 | Frame sync from the source |
| pin_field | input | 1 | Field indicator from the source |
| gen_hs | output | 1 | Generated line sync to the source |
| gen_vs | output | 1 | Generated frame sync to the source |
| pix_valid | output | 1 | Pixel word qualifier |
| pix_data | output | 16 | Right-justified pixel word |
| line_start | output | 1 | Line start pulse |
| frame_start | output | 1 | Frame start pulse |
| field_even | output | 1 | Even-field flag |
| cfg_err | output | 1 | Window configuration error |

## Verification
Pins are driven 2 ns after a rising edge and outputs are read 2 ns after a later rising edge. Data, valid, line-start, frame-start and field results appear two rising edges after the pin change, and the error flag appears one edge after a configuration change. Each table entry therefore waits three edges before it is checked, and the directed pulse tests check the exact second edge and the edge after it. The edge-select test changes the data again 1 ns after the falling edge, so the value expected at that second edge tells the two sampling modes apart. Slave timing is checked by counting pulses and active cycles over a whole number of frames, which does not depend on phase.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic fld;
  } sync_t;
endpackage

// File: rtl/vcap_edge_sampler.sv
module vcap_edge_sampler #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_rise,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import vcap_pkg::*;

  logic [W-1:0] neg_q;

  // falling-edge capture register
  always_ff @(negedge clk) begin
    if (rst) neg_q <= '0;
    else     neg_q <= d;
  end

  // rising-edge register: direct sample or retimed falling sample
  always_ff @(posedge clk) begin
    if (rst)                                 q <= '0;
    else if (edge_e'(sample_rise) == EDGE_RISE) q <= d;
    else                                     q <= neg_q;
  end
endmodule

// File: rtl/vcap_lane_window.sv
module vcap_lane_window #(
  parameter int BUS_W = 16,
  localparam int WW = $clog2(BUS_W + 1),
  localparam int SW = $clog2(BUS_W)
) (
  input  logic [BUS_W-1:0] word,
  input  logic [WW-1:0]    width,
  input  logic [SW-1:0]    shift,
  output logic [BUS_W-1:0] win,
  output logic             err
);
  logic [BUS_W-1:0] mask;
  logic [WW:0]      span;

  for (genvar i = 0; i < BUS_W; i++) begin : g_mask
    assign mask[i] = (WW'(i) < width);
  end

  always_comb begin
    span = {1'b0, width} + (WW + 1)'(shift);
    err  = (width == '0) || (span > (WW + 1)'(BUS_W));
    win  = (word >> shift) & mask;
  end
endmodule

// File: rtl/vcap_sync_gen.sv
module vcap_sync_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] h_active,
  input  logic [CNT_W-1:0] h_total,
  input  logic [CNT_W-1:0] v_active,
  input  logic [CNT_W-1:0] v_total,
  output logic             h_act,
  output logic             v_act
);
  logic [CNT_W-1:0] hcnt, vcnt;
  logic             h_wrap, v_wrap;

  always_comb begin
    h_wrap = ((CNT_W + 1)'(hcnt) + (CNT_W + 1)'(1)) >= {1'b0, h_total};
    v_wrap = ((CNT_W + 1)'(vcnt) + (CNT_W + 1)'(1)) >= {1'b0, v_total};
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt  <= '0;
      vcnt  <= '0;
      h_act <= 1'b0;
      v_act <= 1'b0;
    end else begin
      h_act <= (hcnt < h_active);
      v_act <= (vcnt < v_active);
      if (h_wrap) begin
        hcnt <= '0;
        vcnt <= v_wrap ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_cap_front.sv
module vid_cap_front #(
  parameter int BUS_W = 16,
  parameter int CNT_W = 12,
  localparam int WW = $clog2(BUS_W + 1),
  localparam int SW = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hs_pol,
  input  logic             cfg_vs_pol,
  input  logic             cfg_data_pol,
  input  logic             cfg_field_even_lvl,
  input  logic             cfg_sample_rise,
  input  logic [WW-1:0]    cfg_width,
  input  logic [SW-1:0]    cfg_shift,
  input  logic             cfg_slave,
  input  logic [CNT_W-1:0] cfg_h_active,
  input  logic [CNT_W-1:0] cfg_h_total,
  input  logic [CNT_W-1:0] cfg_v_active,
  input  logic [CNT_W-1:0] cfg_v_total,
  input  logic [BUS_W-1:0] pin_data,
  input  logic             pin_hs,
  input  logic             pin_vs,
  input  logic             pin_field,
  output logic             gen_hs,
  output logic             gen_vs,
  output logic             pix_valid,
  output logic [BUS_W-1:0] pix_data,
  output logic             line_start,
  output logic             frame_start,
  output logic             field_even,
  output logic             cfg_err
);
  import vcap_pkg::*;

  localparam int SAMP_W = BUS_W + $bits(sync_t);

  logic [SAMP_W-1:0] samp_d, samp_q;
  sync_t             raw_sync;
  logic [BUS_W-1:0]  raw_data, data_c, win;
  logic              h_act, v_act, win_err;
  logic              hs_c, vs_c, fld_c, hs_prev, vs_prev;

  assign samp_d = {pin_hs, pin_vs, pin_field, pin_data};

  vcap_edge_sampler #(.W(SAMP_W)) u_samp (
    .clk         (clk),
    .rst         (rst),
    .sample_rise (cfg_sample_rise),
    .d           (samp_d),
    .q           (samp_q)
  );

  assign raw_sync = sync_t'(samp_q[SAMP_W-1:BUS_W]);
  assign raw_data = samp_q[BUS_W-1:0];

  vcap_sync_gen #(.CNT_W(CNT_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_slave),
    .h_active (cfg_h_active),
    .h_total  (cfg_h_total),
    .v_active (cfg_v_active),
    .v_total  (cfg_v_total),
    .h_act    (h_act),
    .v_act    (v_act)
  );

  // generated syncs: registered activity, static polarity applied
  assign gen_hs = h_act ~^ cfg_hs_pol;
  assign gen_vs = v_act ~^ cfg_vs_pol;

  // normalize to active-high
  always_comb begin
    hs_c   = cfg_slave ? h_act : (raw_sync.hs ~^ cfg_hs_pol);
    vs_c   = cfg_slave ? v_act : (raw_sync.vs ~^ cfg_vs_pol);
    fld_c  = raw_sync.fld ~^ cfg_field_even_lvl;
    data_c = raw_data ^ {BUS_W{~cfg_data_pol}};
  end

  vcap_lane_window #(.BUS_W(BUS_W)) u_win (
    .word  (data_c),
    .width (cfg_width),
    .shift (cfg_shift),
    .win   (win),
    .err   (win_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev     <= 1'b0;
      vs_prev     <= 1'b0;
      pix_valid   <= 1'b0;
      pix_data    <= '0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      field_even  <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      hs_prev     <= hs_c;
      vs_prev     <= vs_c;
      pix_valid   <= hs_c && !win_err;
      pix_data    <= (hs_c && !win_err) ? win : '0;
      line_start  <= hs_c && !hs_prev && !win_err;
      frame_start <= vs_c && !vs_prev && !win_err;
      field_even  <= fld_c;
      cfg_err     <= win_err;
    end
  end
endmodule

// File: rtl/vcap_chk.sv
module vcap_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_slave,
  input logic             cfg_hs_pol,
  input logic             cfg_vs_pol,
  input logic             gen_hs,
  input logic             gen_vs,
  input logic             pix_valid,
  input logic [BUS_W-1:0] pix_data,
  input logic             line_start,
  input logic             frame_start,
  input logic             cfg_err
);
  p_line_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  p_line_first_r3: assert property (@(posedge clk) disable iff (rst)
    line_start |-> pix_valid);

  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  p_err_block_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!pix_valid && !line_start && !frame_start));

  p_zero_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (pix_data == '0));

  p_master_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_slave) |-> ((gen_hs == !cfg_hs_pol) && (gen_vs == !cfg_vs_pol)));
endmodule

bind vid_cap_front vcap_chk #(.BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_slave   (cfg_slave),
  .cfg_hs_pol  (cfg_hs_pol),
  .cfg_vs_pol  (cfg_vs_pol),
  .gen_hs      (gen_hs),
  .gen_vs      (gen_vs),
  .pix_valid   (pix_valid),
  .pix_data    (pix_data),
  .line_start  (line_start),
  .frame_start (frame_start),
  .cfg_err     (cfg_err)
);

// File: tb/vid_cap_front_tb.sv
module vid_cap_front_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_hs_pol, cfg_vs_pol, cfg_data_pol, cfg_field_even_lvl;
  logic        cfg_sample_rise, cfg_slave;
  logic [4:0]  cfg_width;
  logic [3:0]  cfg_shift;
  logic [11:0] cfg_h_active, cfg_h_total, cfg_v_active, cfg_v_total;
  logic [15:0] pin_data;
  logic        pin_hs, pin_vs, pin_field;
  logic        gen_hs, gen_vs, pix_valid, line_start, frame_start;
  logic        field_even, cfg_err;
  logic [15:0] pix_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vid_cap_front u_dut (
    .clk(clk), .rst(rst),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_data_pol(cfg_data_pol), .cfg_field_even_lvl(cfg_field_even_lvl),
    .cfg_sample_rise(cfg_sample_rise), .cfg_width(cfg_width),
    .cfg_shift(cfg_shift), .cfg_slave(cfg_slave),
    .cfg_h_active(cfg_h_active), .cfg_h_total(cfg_h_total),
    .cfg_v_active(cfg_v_active), .cfg_v_total(cfg_v_total),
    .pin_data(pin_data), .pin_hs(pin_hs), .pin_vs(pin_vs),
    .pin_field(pin_field), .gen_hs(gen_hs), .gen_vs(gen_vs),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .line_start(line_start), .frame_start(frame_start),
    .field_even(field_even), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic        hs_pol;
    logic        dpol;
    logic [4:0]  w;
    logic [3:0]  sh;
    logic [15:0] d;
    logic        hs;
    logic        ev;
    logic        ee;
    logic [15:0] ed;
  } vec_t;

  // R1 R4 R6 R7 table: polarity, inversion, window, error
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b1, 5'd8,  4'd2,  16'h03FC, 1'b1, 1'b1, 1'b0, 16'h00FF},
    '{1'b1, 1'b1, 5'd8,  4'd2,  16'h0A5C, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 1'b1, 5'd8,  4'd0,  16'h1234, 1'b0, 1'b1, 1'b0, 16'h0034},
    '{1'b0, 1'b1, 5'd8,  4'd0,  16'h1234, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 5'd4,  4'd4,  16'h00A0, 1'b1, 1'b1, 1'b0, 16'h0005},
    '{1'b1, 1'b0, 5'd16, 4'd0,  16'h1234, 1'b1, 1'b1, 1'b0, 16'hEDCB},
    '{1'b1, 1'b1, 5'd10, 4'd6,  16'hFFC0, 1'b1, 1'b1, 1'b0, 16'h03FF},
    '{1'b1, 1'b1, 5'd12, 4'd5,  16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 1'b1, 5'd0,  4'd0,  16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 1'b1, 5'd1,  4'd15, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h0001}
  };

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_test(input logic rise, input logic [15:0] exp);
    cfg_sample_rise = rise;
    pin_hs = 1'b1;
    pin_data = 16'h0000;
    tick(3);
    pin_data = 16'h5A5A;
    #3;
    pin_data = 16'hC3C3;
    tick(2);
    chk("R5 sampled word", 32'(pix_data), 32'(exp));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ls_n, fs_n, val_n, ghs_n, gvs_n, zero_bad;
    rst = 1'b1;
    cfg_hs_pol = 1'b1; cfg_vs_pol = 1'b1; cfg_data_pol = 1'b1;
    cfg_field_even_lvl = 1'b1; cfg_sample_rise = 1'b1; cfg_slave = 1'b0;
    cfg_width = 5'd16; cfg_shift = 4'd0;
    cfg_h_active = 12'd6; cfg_h_total = 12'd10;
    cfg_v_active = 12'd1; cfg_v_total = 12'd4;
    pin_data = 16'hFFFF; pin_hs = 1'b1; pin_vs = 1'b1; pin_field = 1'b1;
    tick(3);
    // R12 reset state
    chk("R12 pix_valid", 32'(pix_valid), 0);
    chk("R12 pix_data", 32'(pix_data), 0);
    chk("R12 line_start", 32'(line_start), 0);
    chk("R12 frame_start", 32'(frame_start), 0);
    chk("R12 field_even", 32'(field_even), 0);
    rst = 1'b0;
    pin_hs = 1'b0; pin_vs = 1'b0;
    tick(2);

    foreach (VECS[i]) begin
      cfg_hs_pol = VECS[i].hs_pol;
      cfg_data_pol = VECS[i].dpol;
      cfg_width = VECS[i].w;
      cfg_shift = VECS[i].sh;
      pin_data = VECS[i].d;
      pin_hs = VECS[i].hs;
      tick(3);
      chk("R1/R7 table valid", 32'(pix_valid), 32'(VECS[i].ev));
      chk("R4/R6/R11 table data", 32'(pix_data), 32'(VECS[i].ed));
      chk("R7 table error", 32'(cfg_err), 32'(VECS[i].ee));
    end

    // R1 R3 latency and pulse
    cfg_hs_pol = 1'b1; cfg_data_pol = 1'b1; cfg_width = 5'd16; cfg_shift = 4'd0;
    pin_hs = 1'b0;
    tick(3);
    pin_hs = 1'b1; pin_data = 16'hBEEF;
    tick(1);
    chk("R1 valid after one edge", 32'(pix_valid), 0);
    chk("R3 no early line_start", 32'(line_start), 0);
    tick(1);
    chk("R3 line_start pulse", 32'(line_start), 1);
    chk("R1 valid after two edges", 32'(pix_valid), 1);
    chk("R6 first pixel", 32'(pix_data), 32'h0000BEEF);
    tick(1);
    chk("R3 line_start single cycle", 32'(line_start), 0);

    // R2 frame start with active-low frame sync
    cfg_vs_pol = 1'b0; pin_vs = 1'b1;
    tick(3);
    chk("R2 no frame_start while inactive", 32'(frame_start), 0);
    pin_vs = 1'b0;
    tick(2);
    chk("R2 frame_start pulse", 32'(frame_start), 1);
    tick(1);
    chk("R2 frame_start single cycle", 32'(frame_start), 0);

    // R7 error suppresses starts
    pin_hs = 1'b0; pin_vs = 1'b1; cfg_width = 5'd12; cfg_shift = 4'd8;
    tick(3);
    pin_hs = 1'b1; pin_vs = 1'b0;
    tick(2);
    chk("R7 line_start held", 32'(line_start), 0);
    chk("R7 frame_start held", 32'(frame_start), 0);
    chk("R7 cfg_err set", 32'(cfg_err), 1);
    cfg_width = 5'd16; cfg_shift = 4'd0;

    // R5 sampling edge
    edge_test(1'b1, 16'hC3C3);
    edge_test(1'b0, 16'h5A5A);
    cfg_sample_rise = 1'b1;

    // R8 field level
    cfg_field_even_lvl = 1'b1; pin_field = 1'b1;
    tick(2);
    chk("R8 field match", 32'(field_even), 1);
    cfg_field_even_lvl = 1'b0;
    tick(2);
    chk("R8 field mismatch", 32'(field_even), 0);

    // R10 master idle levels
    cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b1;
    #1;
    chk("R10 gen_hs idle", 32'(gen_hs), 1);
    chk("R10 gen_vs idle", 32'(gen_vs), 0);

    // R9 slave generation, pins toggled and ignored
    cfg_slave = 1'b1;
    tick(50);
    ls_n = 0; fs_n = 0; val_n = 0; ghs_n = 0; gvs_n = 0; zero_bad = 0;
    for (int c = 0; c < 80; c++) begin
      pin_hs = ~pin_hs;
      pin_vs = (c % 3) == 0;
      tick(1);
      ls_n += int'(line_start);
      fs_n += int'(frame_start);
      val_n += int'(pix_valid);
      ghs_n += int'(gen_hs == 1'b0);
      gvs_n += int'(gen_vs == 1'b1);
      if (!pix_valid && pix_data != 16'h0) zero_bad++;
    end
    chk("R9 line_start count", 32'(ls_n), 8);
    chk("R9 frame_start count", 32'(fs_n), 2);
    chk("R9 valid cycles", 32'(val_n), 48);
    chk("R9 gen_hs active cycles", 32'(ghs_n), 48);
    chk("R9 gen_vs active cycles", 32'(gvs_n), 20);
    chk("R11 zero while idle", 32'(zero_bad), 0);
    cfg_slave = 1'b0;
    tick(2);
    chk("R10 gen_hs idle after slave", 32'(gen_hs), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule